// File: doc/BRIEF.md
# DCF Channel Access Backoff Timer

This block paces channel access for a single transmit queue that contends under distributed coordination. A configuration stage holds the slot time, the short interframe space, the arbitration slot count, the minimum and maximum contention windows, an acknowledgement airtime and a switch that suppresses the random wait after a good transmission. Each write is sanitised as it is captured. The stage also turns the microsecond settings into clock-cycle durations for the DIFS, PIFS and EIFS intervals, using a clocks-per-microsecond ratio.

When a frame is pending and the medium is idle, a sequencer waits one SIFS and then the configured number of arbitration slots. It then counts a random number of idle slots and raises a grant. A busy medium freezes the remaining slot count and sends the sequencer back to wait for idle, after which the SIFS and arbitration wait run again in full. At the end of a transmission the window doubles (saturating) on failure or drops to the minimum on success, and a fresh backoff is drawn from a 10-bit LFSR masked by the new window.

Top module: `dcf_backoff_timer`

## Requirements
- R1: A written arbitration slot count above 252 (0xFC) is stored as 252; values up to 252 are stored unchanged, and the stored value appears on `aifsEff`.
- R2: A written contention window W is first limited to 1023, then stored as W if W+1 is a power of two; else as W-1 if W is a power of two; else as the next power of two above W, minus 1. Applies to both minimum (`cwMinEff`) and maximum (`cwMaxEff`).
- R3: A write whose slot time is below 6 us, or whose slot time times `clkPerUs` exceeds 1000 clocks, leaves the stored slot time unchanged; the other fields of that write are still taken. `slotClk` shows stored slot time times `clkPerUs`.
- R4: `difsClk` = (SIFS + 2*slot)*`clkPerUs`, `pifsClk` = (SIFS + slot)*`clkPerUs`, `eifsClk` = (ack + SIFS + 2*slot)*`clkPerUs`.
- R5: With `txReq` high and the medium idle, if the inputs change after clock edge 0, `grant` is high after edge S+(A+B)*T+2, counting edge 0 as edge 1. Here S is the SIFS in clocks, T is the slot in clocks, A is the stored arbitration count and B is `backoffCnt` when the attempt starts.
- R6: While `mediumBusy` is high, `grant` stays low and `backoffCnt` holds its value. After the medium goes idle, the full SIFS and arbitration wait run again before the remaining backoff resumes.
- R7: `grant` stays high until `txDone`; busy medium does not drop it. A `txDone` while `grant` is low changes neither `curCw` nor `backoffCnt`.
- R8: On `txDone` with `txOk` low, `curCw` becomes (cw<<1)|1, saturating at `cwMaxEff`, and `backoffCnt` becomes a value no larger than the new `curCw`.
- R9: On `txDone` with `txOk` high, `curCw` becomes `cwMinEff` and `backoffCnt` becomes a value no larger than it.
- R10: With the post-frame backoff disable bit set, a successful `txDone` sets `backoffCnt` to 0.
- R11: After reset: `grant`=0, `backoffCnt`=0, `curCw`=15, `cwMaxEff`=1023, `aifsEff`=2, slot 9 us, SIFS 16 us, ack 44 us.
- R12: A configuration write sets `curCw` to the new normalised minimum window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clkPerUs | input | 8 | Clock cycles per microsecond |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSlotUs | input | 8 | Requested slot time, us |
| cfgSifsUs | input | 8 | SIFS, us |
| cfgAifs | input | 8 | Requested arbitration slot count |
| cfgCwMin | input | 16 | Requested minimum window |
| cfgCwMax | input | 16 | Requested maximum window |
| cfgAckUs | input | 10 | Ack airtime at lowest rate, us |
| cfgPfbDis | input | 1 | Suppress backoff after success |
| txReq | input | 1 | Frame pending |
| mediumBusy | input | 1 | Medium busy indication |
| txDone | input | 1 | Transmission finished (one cycle) |
| txOk | input | 1 | Outcome with `txDone`: 1 success |
| grant | output | 1 | Channel access granted |
| curCw | output | 10 | Current contention window |
| backoffCnt | output | 10 | Remaining backoff slots |
| aifsEff | output | 8 | Stored arbitration slot count |
| cwMinEff | output | 10 | Stored minimum window |
| cwMaxEff | output | 10 | Stored maximum window |
| slotClk | output | 20 | Slot duration, clocks |
| difsClk | output | 20 | DIFS, clocks |
| pifsClk | output | 20 | PIFS, clocks |
| eifsClk | output | 20 | EIFS, clocks |

## Verification
On every cycle the assertions hold the stored arbitration count at or below 252, keep both windows of the form 2^n-1, and hold the slot register through a rejected write. They also keep the grant low while the medium is busy, keep it high until completion, and bound each fresh backoff by the window it was drawn from. The exact cycle of the grant, the restart of the interframe wait after a busy spell, the doubling and saturation sequence, and the rounding of particular window requests can only be seen in the bench's directed scenarios.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  parameter int CW_W     = 10;
  parameter int CW_REQ_W = 16;
  localparam int CW_LIMIT = (1 << CW_W) - 1;
  parameter logic [CW_W-1:0] LFSR_TAPS = 'h240;
  parameter logic [CW_W-1:0] LFSR_SEED = 'h1A5;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_SIFS,
    ST_AIFS,
    ST_BOFF,
    ST_GRANT
  } accState_t;

  typedef struct packed {
    logic ldSifs;
    logic ldSlot;
    logic ldAifs;
    logic decAifs;
    logic decBo;
    logic countTick;
    logic endOk;
    logic endFail;
  } accStrobe_t;

  // Force a window request to 2^n-1 form within the CW_W-bit limit.
  function automatic logic [CW_W-1:0] cwNormalize(input logic [CW_REQ_W-1:0] req);
    logic [CW_W-1:0] w;
    logic [CW_W-1:0] s;
    w = (req > CW_REQ_W'(CW_LIMIT)) ? CW_W'(CW_LIMIT) : req[CW_W-1:0];
    s = w;
    for (int i = 1; i < CW_W; i = i * 2) s = s | (s >> i);
    if (s == w) return w;
    else if ((w & (w - 1'b1)) == '0) return w - 1'b1;
    else return s;
  endfunction
endpackage

// File: rtl/dcf_cfg_regs.sv
module dcf_cfg_regs
  import dcf_pkg::*;
#(
  parameter int US_W         = 8,
  parameter int RATIO_W      = 8,
  parameter int AIFS_W       = 8,
  parameter int ACK_W        = 10,
  parameter int CLK_W        = 20,
  parameter int AIFS_MAX     = 252,
  parameter int SLOT_MIN_US  = 6,
  parameter int SLOT_CLK_MAX = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RATIO_W-1:0]  clkPerUs,
  input  logic                cfgWe,
  input  logic [US_W-1:0]     cfgSlotUs,
  input  logic [US_W-1:0]     cfgSifsUs,
  input  logic [AIFS_W-1:0]   cfgAifs,
  input  logic [CW_REQ_W-1:0] cfgCwMin,
  input  logic [CW_REQ_W-1:0] cfgCwMax,
  input  logic [ACK_W-1:0]    cfgAckUs,
  input  logic                cfgPfbDis,
  output logic [CW_W-1:0]     cwMinNext,
  output logic [AIFS_W-1:0]   aifsQ,
  output logic [CW_W-1:0]     cwMinQ,
  output logic [CW_W-1:0]     cwMaxQ,
  output logic                pfbDisQ,
  output logic [CLK_W-1:0]    slotClk,
  output logic [CLK_W-1:0]    sifsClk,
  output logic [CLK_W-1:0]    difsClk,
  output logic [CLK_W-1:0]    pifsClk,
  output logic [CLK_W-1:0]    eifsClk
);
  localparam int SUM_W       = ACK_W + 2;
  localparam int RST_SLOT_US = 9;
  localparam int RST_SIFS_US = 16;
  localparam int RST_AIFS    = 2;
  localparam int RST_ACK_US  = 44;
  localparam int RST_CW_MIN  = 15;

  logic [US_W-1:0]  slotUsQ, sifsUsQ;
  logic [ACK_W-1:0] ackUsQ;
  logic [CLK_W-1:0] reqSlotClk;
  logic             slotOk;
  logic [SUM_W-1:0] difsUs, pifsUs, eifsUs;

  assign reqSlotClk = CLK_W'(cfgSlotUs) * CLK_W'(clkPerUs);
  assign slotOk     = (cfgSlotUs >= US_W'(SLOT_MIN_US)) &&
                      (reqSlotClk <= CLK_W'(SLOT_CLK_MAX));
  assign cwMinNext  = cwNormalize(cfgCwMin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotUsQ <= US_W'(RST_SLOT_US);
      sifsUsQ <= US_W'(RST_SIFS_US);
      aifsQ   <= AIFS_W'(RST_AIFS);
      cwMinQ  <= CW_W'(RST_CW_MIN);
      cwMaxQ  <= CW_W'(CW_LIMIT);
      ackUsQ  <= ACK_W'(RST_ACK_US);
      pfbDisQ <= 1'b0;
    end else if (cfgWe) begin
      if (slotOk) slotUsQ <= cfgSlotUs;
      sifsUsQ <= cfgSifsUs;
      aifsQ   <= (cfgAifs > AIFS_W'(AIFS_MAX)) ? AIFS_W'(AIFS_MAX) : cfgAifs;
      cwMinQ  <= cwMinNext;
      cwMaxQ  <= cwNormalize(cfgCwMax);
      ackUsQ  <= cfgAckUs;
      pfbDisQ <= cfgPfbDis;
    end
  end

  assign pifsUs  = SUM_W'(sifsUsQ) + SUM_W'(slotUsQ);
  assign difsUs  = pifsUs + SUM_W'(slotUsQ);
  assign eifsUs  = difsUs + SUM_W'(ackUsQ);
  assign slotClk = CLK_W'(slotUsQ) * CLK_W'(clkPerUs);
  assign sifsClk = CLK_W'(sifsUsQ) * CLK_W'(clkPerUs);
  assign difsClk = CLK_W'(difsUs) * CLK_W'(clkPerUs);
  assign pifsClk = CLK_W'(pifsUs) * CLK_W'(clkPerUs);
  assign eifsClk = CLK_W'(eifsUs) * CLK_W'(clkPerUs);

  a_r1_aifs_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    aifsQ <= AIFS_W'(AIFS_MAX));
  a_r2_cw_form: assert property (@(posedge clk) disable iff (!rst_n)
    (((cwMinQ + 1'b1) & cwMinQ) == '0) && (((cwMaxQ + 1'b1) & cwMaxQ) == '0));
  a_r3_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWe && !slotOk) |=> $stable(slotUsQ));
endmodule

// File: rtl/dcf_access_ctrl.sv
module dcf_access_ctrl
  import dcf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txReq,
  input  logic       mediumBusy,
  input  logic       txDone,
  input  logic       txOk,
  input  logic       tickEnd,
  input  logic       aifsZero,
  input  logic       aifsLast,
  input  logic       boZero,
  output accStrobe_t strb,
  output logic       grant
);
  accState_t st, stNext;
  logic      hold;

  assign hold = mediumBusy || !txReq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_WAIT;
    else        st <= stNext;
  end

  always_comb begin
    stNext = st;
    strb   = '0;
    case (st)
      ST_WAIT: begin
        if (txReq && !mediumBusy) begin
          stNext      = ST_SIFS;
          strb.ldSifs = 1'b1;
        end
      end
      ST_SIFS: begin
        if (hold) stNext = ST_WAIT;
        else if (tickEnd) begin
          strb.ldSlot = 1'b1;
          if (aifsZero) stNext = ST_BOFF;
          else begin
            stNext      = ST_AIFS;
            strb.ldAifs = 1'b1;
          end
        end else strb.countTick = 1'b1;
      end
      ST_AIFS: begin
        if (hold) stNext = ST_WAIT;
        else if (tickEnd) begin
          strb.ldSlot = 1'b1;
          if (aifsLast) stNext = ST_BOFF;
          else          strb.decAifs = 1'b1;
        end else strb.countTick = 1'b1;
      end
      ST_BOFF: begin
        if (hold) stNext = ST_WAIT;
        else if (boZero) stNext = ST_GRANT;
        else if (tickEnd) begin
          strb.decBo  = 1'b1;
          strb.ldSlot = 1'b1;
        end else strb.countTick = 1'b1;
      end
      ST_GRANT: begin
        if (txDone) begin
          stNext = ST_WAIT;
          if (txOk) strb.endOk   = 1'b1;
          else      strb.endFail = 1'b1;
        end
      end
      default: stNext = ST_WAIT;
    endcase
  end

  assign grant = (st == ST_GRANT);

  a_r6_busy_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (mediumBusy && !grant) |=> !grant);
  a_r7_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !txDone) |=> grant);
endmodule

// File: rtl/dcf_backoff_dp.sv
module dcf_backoff_dp
  import dcf_pkg::*;
#(
  parameter int AIFS_W = 8,
  parameter int CLK_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  accStrobe_t        strb,
  input  logic              cfgWe,
  input  logic [CW_W-1:0]   cwMinNext,
  input  logic [CLK_W-1:0]  sifsClk,
  input  logic [CLK_W-1:0]  slotClk,
  input  logic [AIFS_W-1:0] aifsCfg,
  input  logic [CW_W-1:0]   cwMin,
  input  logic [CW_W-1:0]   cwMax,
  input  logic              pfbDis,
  output logic              tickEnd,
  output logic              aifsZero,
  output logic              aifsLast,
  output logic              boZero,
  output logic [CW_W-1:0]   cw,
  output logic [CW_W-1:0]   boCnt
);
  localparam int RST_CW = 15;

  logic [CLK_W-1:0]  tick;
  logic [AIFS_W-1:0] aifsLeft;
  logic [CW_W-1:0]   lfsr;
  logic [CW_W:0]     cwWide;
  logic [CW_W-1:0]   cwGrown;

  assign cwWide  = {cw, 1'b1};
  assign cwGrown = (cwWide > {1'b0, cwMax}) ? cwMax : cwWide[CW_W-1:0];

  assign tickEnd  = (tick <= CLK_W'(1));
  assign aifsZero = (aifsCfg == '0);
  assign aifsLast = (aifsLeft <= AIFS_W'(1));
  assign boZero   = (boCnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= LFSR_SEED;
    else        lfsr <= {lfsr[CW_W-2:0], ^(lfsr & LFSR_TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= '0;
    else if (strb.ldSifs) tick <= sifsClk;
    else if (strb.ldSlot) tick <= slotClk;
    else if (strb.countTick && tick != '0) tick <= tick - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) aifsLeft <= '0;
    else if (strb.ldAifs)  aifsLeft <= aifsCfg;
    else if (strb.decAifs) aifsLeft <= aifsLeft - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw    <= CW_W'(RST_CW);
      boCnt <= '0;
    end else if (cfgWe) begin
      cw <= cwMinNext;
    end else if (strb.endOk) begin
      cw    <= cwMin;
      boCnt <= pfbDis ? '0 : (lfsr & cwMin);
    end else if (strb.endFail) begin
      cw    <= cwGrown;
      boCnt <= lfsr & cwGrown;
    end else if (strb.decBo) begin
      boCnt <= boCnt - 1'b1;
    end
  end

  a_r8_fail_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.endFail && !cfgWe) |=> (boCnt <= cw) && (cw <= cwMax));
  a_r9_ok_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.endOk && !cfgWe) |=> (cw == cwMin) && (boCnt <= cwMin));
  a_r10_pfb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.endOk && pfbDis && !cfgWe) |=> (boCnt == '0));
endmodule

// File: rtl/dcf_backoff_timer.sv
module dcf_backoff_timer
  import dcf_pkg::*;
#(
  parameter int US_W         = 8,
  parameter int RATIO_W      = 8,
  parameter int AIFS_W       = 8,
  parameter int ACK_W        = 10,
  parameter int CLK_W        = 20,
  parameter int AIFS_MAX     = 252,
  parameter int SLOT_MIN_US  = 6,
  parameter int SLOT_CLK_MAX = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RATIO_W-1:0]  clkPerUs,
  input  logic                cfgWe,
  input  logic [US_W-1:0]     cfgSlotUs,
  input  logic [US_W-1:0]     cfgSifsUs,
  input  logic [AIFS_W-1:0]   cfgAifs,
  input  logic [CW_REQ_W-1:0] cfgCwMin,
  input  logic [CW_REQ_W-1:0] cfgCwMax,
  input  logic [ACK_W-1:0]    cfgAckUs,
  input  logic                cfgPfbDis,
  input  logic                txReq,
  input  logic                mediumBusy,
  input  logic                txDone,
  input  logic                txOk,
  output logic                grant,
  output logic [CW_W-1:0]     curCw,
  output logic [CW_W-1:0]     backoffCnt,
  output logic [AIFS_W-1:0]   aifsEff,
  output logic [CW_W-1:0]     cwMinEff,
  output logic [CW_W-1:0]     cwMaxEff,
  output logic [CLK_W-1:0]    slotClk,
  output logic [CLK_W-1:0]    difsClk,
  output logic [CLK_W-1:0]    pifsClk,
  output logic [CLK_W-1:0]    eifsClk
);
  accStrobe_t       strb;
  logic [CW_W-1:0]  cwMinNext;
  logic             pfbDisQ;
  logic [CLK_W-1:0] sifsClk;
  logic             tickEnd, aifsZero, aifsLast, boZero;

  dcf_cfg_regs #(
    .US_W(US_W), .RATIO_W(RATIO_W), .AIFS_W(AIFS_W), .ACK_W(ACK_W),
    .CLK_W(CLK_W), .AIFS_MAX(AIFS_MAX), .SLOT_MIN_US(SLOT_MIN_US),
    .SLOT_CLK_MAX(SLOT_CLK_MAX)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .clkPerUs(clkPerUs), .cfgWe(cfgWe),
    .cfgSlotUs(cfgSlotUs), .cfgSifsUs(cfgSifsUs), .cfgAifs(cfgAifs),
    .cfgCwMin(cfgCwMin), .cfgCwMax(cfgCwMax), .cfgAckUs(cfgAckUs),
    .cfgPfbDis(cfgPfbDis), .cwMinNext(cwMinNext), .aifsQ(aifsEff),
    .cwMinQ(cwMinEff), .cwMaxQ(cwMaxEff), .pfbDisQ(pfbDisQ),
    .slotClk(slotClk), .sifsClk(sifsClk), .difsClk(difsClk),
    .pifsClk(pifsClk), .eifsClk(eifsClk)
  );

  dcf_access_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .txReq(txReq), .mediumBusy(mediumBusy),
    .txDone(txDone), .txOk(txOk), .tickEnd(tickEnd), .aifsZero(aifsZero),
    .aifsLast(aifsLast), .boZero(boZero), .strb(strb), .grant(grant)
  );

  dcf_backoff_dp #(.AIFS_W(AIFS_W), .CLK_W(CLK_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cfgWe(cfgWe),
    .cwMinNext(cwMinNext), .sifsClk(sifsClk), .slotClk(slotClk),
    .aifsCfg(aifsEff), .cwMin(cwMinEff), .cwMax(cwMaxEff), .pfbDis(pfbDisQ),
    .tickEnd(tickEnd), .aifsZero(aifsZero), .aifsLast(aifsLast),
    .boZero(boZero), .cw(curCw), .boCnt(backoffCnt)
  );
endmodule

// File: tb/dcf_backoff_timer_tb.sv
`timescale 1ns/1ps
module dcf_backoff_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clkPerUs = 8'd1;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgSlotUs = '0, cfgSifsUs = '0, cfgAifs = '0;
  logic [15:0] cfgCwMin = '0, cfgCwMax = '0;
  logic [9:0]  cfgAckUs = '0;
  logic        cfgPfbDis = 1'b0;
  logic        txReq = 1'b0, mediumBusy = 1'b0, txDone = 1'b0, txOk = 1'b0;
  logic        grant;
  logic [9:0]  curCw, backoffCnt, cwMinEff, cwMaxEff;
  logic [7:0]  aifsEff;
  logic [19:0] slotClk, difsClk, pifsClk, eifsClk;

  int nChk = 0;
  int nErr = 0;
  // bench model of the timing configuration (clkPerUs = 1 during access tests)
  int mSifs = 0, mSlot = 0, mAifs = 0;

  always #2 clk = ~clk;

  dcf_backoff_timer dut_i (
    .clk(clk), .rst_n(rst_n), .clkPerUs(clkPerUs), .cfgWe(cfgWe),
    .cfgSlotUs(cfgSlotUs), .cfgSifsUs(cfgSifsUs), .cfgAifs(cfgAifs),
    .cfgCwMin(cfgCwMin), .cfgCwMax(cfgCwMax), .cfgAckUs(cfgAckUs),
    .cfgPfbDis(cfgPfbDis), .txReq(txReq), .mediumBusy(mediumBusy),
    .txDone(txDone), .txOk(txOk), .grant(grant), .curCw(curCw),
    .backoffCnt(backoffCnt), .aifsEff(aifsEff), .cwMinEff(cwMinEff),
    .cwMaxEff(cwMaxEff), .slotClk(slotClk), .difsClk(difsClk),
    .pifsClk(pifsClk), .eifsClk(eifsClk)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
  endtask

  task automatic cfgWrite(input int slot, input int sifs, input int aifs,
                          input int cmin, input int cmax, input int ack, input bit pfb);
    @(negedge clk);
    cfgSlotUs = 8'(slot); cfgSifsUs = 8'(sifs); cfgAifs = 8'(aifs);
    cfgCwMin = 16'(cmin); cfgCwMax = 16'(cmax); cfgAckUs = 10'(ack);
    cfgPfbDis = pfb; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // counts edges from the request to the grant; starts and ends at a negedge
  task automatic measure(output int n);
    n = 0;
    for (int i = 0; i < 8000; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (grant) break;
    end
  endtask

  task automatic runAccess(input string req, output int b);
    int n;
    b = int'(backoffCnt);
    txReq = 1'b1;
    measure(n);
    chk(req, n, mSifs + (mAifs + b) * mSlot + 2);
  endtask

  task automatic finishTx(input bit ok);
    txDone = 1'b1; txOk = ok; txReq = 1'b0;
    @(negedge clk);
    txDone = 1'b0; txOk = 1'b0;
  endtask

  task automatic tReset();
    chk("R11 grant", int'(grant), 0);
    chk("R11 backoffCnt", int'(backoffCnt), 0);
    chk("R11 curCw", int'(curCw), 15);
    chk("R11 cwMaxEff", int'(cwMaxEff), 1023);
    chk("R11 aifsEff", int'(aifsEff), 2);
    chk("R11 slotClk", int'(slotClk), 9);
    chk("R11 eifsClk", int'(eifsClk), 44 + 16 + 18);
  endtask

  task automatic tAifsClamp();
    cfgWrite(9, 16, 255, 15, 1023, 44, 0);
    chk("R1 aifs 255", int'(aifsEff), 252);
    cfgWrite(9, 16, 252, 15, 1023, 44, 0);
    chk("R1 aifs 252", int'(aifsEff), 252);
    cfgWrite(9, 16, 251, 15, 1023, 44, 0);
    chk("R1 aifs 251", int'(aifsEff), 251);
  endtask

  task automatic tCwNorm();
    cfgWrite(9, 16, 2, 20, 5000, 44, 0);
    chk("R2 min 20", int'(cwMinEff), 31);
    chk("R2 max 5000", int'(cwMaxEff), 1023);
    chk("R12 curCw after write", int'(curCw), 31);
    cfgWrite(9, 16, 2, 16, 64, 44, 0);
    chk("R2 min 16", int'(cwMinEff), 15);
    chk("R2 max 64", int'(cwMaxEff), 63);
    chk("R12 curCw after write", int'(curCw), 15);
    cfgWrite(9, 16, 2, 7, 2, 44, 0);
    chk("R2 min 7", int'(cwMinEff), 7);
    chk("R2 max 2", int'(cwMaxEff), 1);
    cfgWrite(9, 16, 2, 1, 0, 44, 0);
    chk("R2 min 1", int'(cwMinEff), 1);
    chk("R2 max 0", int'(cwMaxEff), 0);
  endtask

  task automatic tSlot();
    cfgWrite(6, 16, 2, 15, 1023, 44, 0);
    chk("R3 slot 6 taken", int'(slotClk), 6);
    cfgWrite(5, 16, 2, 15, 1023, 44, 0);
    chk("R3 slot 5 rejected", int'(slotClk), 6);
    clkPerUs = 8'd8;
    cfgWrite(200, 16, 7, 15, 1023, 44, 0);
    chk("R3 slot too many clocks rejected", int'(slotClk), 48);
    chk("R3 other fields taken", int'(aifsEff), 7);
    cfgWrite(100, 16, 2, 15, 1023, 44, 0);
    chk("R3 slot 100 taken", int'(slotClk), 800);
    clkPerUs = 8'd1;
  endtask

  task automatic tIfs();
    cfgWrite(6, 2, 2, 15, 63, 10, 0);
    chk("R4 difs", int'(difsClk), 14);
    chk("R4 pifs", int'(pifsClk), 8);
    chk("R4 eifs", int'(eifsClk), 24);
    clkPerUs = 8'd3;
    @(negedge clk);
    chk("R4 difs x3", int'(difsClk), 42);
    chk("R4 eifs x3", int'(eifsClk), 72);
    clkPerUs = 8'd1;
    mSifs = 2; mSlot = 6; mAifs = 2;
  endtask

  task automatic tAccessHold();
    int b;
    runAccess("R5 first access", b);
    mediumBusy = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 grant held while busy", int'(grant), 1);
    mediumBusy = 1'b0;
    finishTx(1'b1);
    chk("R7 grant drops on done", int'(grant), 0);
    b = int'(backoffCnt);
    txDone = 1'b1; txOk = 1'b0;
    @(negedge clk);
    txDone = 1'b0;
    chk("R7 stray done cw", int'(curCw), 15);
    chk("R7 stray done backoff", int'(backoffCnt), b);
  endtask

  task automatic tFail();
    int b;
    int expCw = 15;
    for (int k = 0; k < 4; k++) begin
      runAccess("R5 access before failure", b);
      finishTx(1'b0);
      expCw = (((expCw << 1) | 1) > 63) ? 63 : ((expCw << 1) | 1);
      chk("R8 cw growth", int'(curCw), expCw);
      chk("R8 backoff within window", int'(backoffCnt <= curCw), 1);
    end
  endtask

  task automatic tBusy();
    int b;
    int n;
    for (int k = 0; k < 8; k++) begin
      if (backoffCnt >= 10'd1) break;
      runAccess("R5 access to draw backoff", b);
      finishTx(1'b0);
    end
    b = int'(backoffCnt);
    txReq = 1'b1;
    repeat (mSifs + mAifs * mSlot + 3) @(posedge clk);
    @(negedge clk);
    mediumBusy = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (grant || backoffCnt != 10'(b)) begin
        chk("R6 frozen while busy (grant,cnt)", int'(grant) * 4096 + int'(backoffCnt), b);
      end
    end
    chk("R6 count frozen", int'(backoffCnt), b);
    chk("R6 no grant while busy", int'(grant), 0);
    mediumBusy = 1'b0;
    measure(n);
    chk("R6 full wait after idle", n, mSifs + (mAifs + b) * mSlot + 2);
    finishTx(1'b0);
  endtask

  task automatic tOk();
    int b;
    runAccess("R5 access before success", b);
    finishTx(1'b1);
    chk("R9 cw reset to min", int'(curCw), 15);
    chk("R9 backoff within min", int'(backoffCnt <= 10'd15), 1);
  endtask

  task automatic tPfb();
    int b;
    cfgWrite(6, 2, 2, 15, 63, 10, 1);
    runAccess("R5 access with pfb", b);
    finishTx(1'b1);
    chk("R10 no backoff after success", int'(backoffCnt), 0);
    runAccess("R5 access zero backoff", b);
    chk("R10 zero-backoff access length", b, 0);
    finishTx(1'b0);
    chk("R8 failure still draws within window", int'(backoffCnt <= curCw), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tAifsClamp();
    tCwNorm();
    tSlot();
    tIfs();
    tAccessHold();
    tFail();
    tBusy();
    tOk();
    tPfb();
    summary();
    $finish;
  end
endmodule